// File: doc/BRIEF.md
# Multiplexed-Address Dynamic RAM Model

A synthesizable behavioural model of a one-bit-wide dynamic RAM whose row and column addresses share one bus. The row half of the address is captured when the row strobe falls, and the column half when the column strobe falls. Keeping the row strobe low holds the row open, so that a train of column strobes can read or write many bits of that row without selecting it again (fast page mode). The array is square, with 2^AW rows of 2^AW one-bit cells. AW is 10 for the full-size part and 5 by default, which keeps the model small.

Rows can be refreshed in two ways. In the first, the row strobe falls while the column strobe is high, and the row is taken from the external bus. In the second, the column strobe falls before the row strobe, and an internal counter picks the row and then advances. With DECAY_EN set, every row carries an age timer. A row that goes RETAIN clock cycles without any activation, access or refresh loses its contents. This lets the surrounding system prove that its refresh scheduling is correct.

All strobes are active low and are sampled on the rising clock edge. An edge of a strobe is the difference between two consecutive samples.

Top module: `dram_mux_model`

## Requirements
- R1: After reset, dout_valid and dout are 0, every cell holds 0 and the internal refresh counter is 0.
- R2: A RAS fall with CAS high latches addr as the open row. A later CAS fall latches addr as the column. With we_n high this reads the cell: dout_valid is 1 and dout holds the cell's value from the edge that samples CAS low. With we_n low it writes din into the cell.
- R3: While RAS stays low, each new CAS fall accesses a different column of the same open row, and no new row address is taken.
- R4: Any edge that samples CAS high leaves dout_valid at 0, and dout reads 0 while dout_valid is 0. A write cycle never raises dout_valid.
- R5: A write changes only the addressed cell. Every other cell of the open row, and of every other row, keeps its value.
- R6: A CAS fall while RAS is high, followed by CAS rising with no RAS fall in between, has no effect: no write, no output and no change to the refresh counter.
- R7: With DECAY_EN=1, a row that goes RETAIN cycles without an activation, access or refresh reads as all zeros afterwards.
- R8: A RAS fall with CAS high (RAS-only refresh) refreshes the row at addr, so its data survives across intervals that would otherwise exceed RETAIN.
- R9: When CAS is already sampled low at the edge where RAS falls, the row named by the internal counter is refreshed and addr is ignored. The counter then advances by one, wrapping from 2^AW-1 to 0. dout_valid stays 0 during this cycle.
- R10: Opening a row with RAS, and each read or write access within it, restarts that row's retention time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for strobes and data |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Low selects a write, high a read |
| addr | input | AW | Shared row/column address bus |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, 0 while not valid |
| dout_valid | output | 1 | Read data is being driven |

## Verification
A wrong latched row or column shows up on the first read of the cycle in which it is used, one edge after CAS falls: the bit returned belongs to another cell. A refresh counter that starts at the wrong value, skips a step or was advanced by a stray strobe refreshes the wrong rows. That error only becomes visible after a full retention interval, when a row the bench expects to hold data reads zero, or a row it expects to be empty still holds data. For that reason the bench places its decay checks in windows of about 1400 and 2200 cycles, so that no check depends on the exact expiry cycle. A valid flag that does not drop would appear on the very next edge that samples CAS high.

// File: rtl/dram_pkg.sv
// Shared types for the multiplexed-address DRAM model.
// Assumes: nothing beyond IEEE 1800-2017.
package dram_pkg;
    // Kind of RAS cycle currently in progress
    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,   // RAS high, no row open
        CYC_OPEN = 2'd1,   // row latched from bus, accesses allowed
        CYC_CBR  = 2'd2    // counter-driven refresh, no accesses
    } cyc_e;
endpackage

// File: rtl/dram_refresh_ctr.sv
// Internal refresh row counter.
// Advances by one on each CAS-before-RAS refresh and wraps at 2^AW.
// Assumes: fire is a single-cycle pulse from the strobe controller.
module dram_refresh_ctr #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    output logic [AW-1:0] cnt
);
    // Count refresh cycles; natural overflow gives the wrap
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (fire) cnt <= cnt + 1'b1;
    end

    a_r9_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cnt == $past(cnt) + 1'b1);
    a_r9_ctr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(cnt));
endmodule

// File: rtl/dram_strobe_ctrl.sv
// Strobe decoder for the multiplexed-address DRAM model.
// Samples RAS/CAS each clock and detects their falling edges. Latches the
// row, classifies each RAS cycle (open row or counter refresh) and issues
// refresh, read and write pulses.
// Assumes: strobes are synchronous to clk; a CAS fall in the same sample as
// the RAS fall is treated as a plain row activation and no access.
module dram_strobe_ctrl
    import dram_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ref_cnt,
    output logic          ref_en,
    output logic [AW-1:0] ref_row,
    output logic          cbr_fire,
    output logic          rd_en,
    output logic          wr_en,
    output logic [AW-1:0] acc_row,
    output logic [AW-1:0] acc_col
);
    logic          ras_q, cas_q;
    logic          pend_q;
    cyc_e          cyc_q;
    logic [AW-1:0] row_q;
    logic          ras_fall, cas_fall, act_fire, acc;

    // Edge detection and event classification
    always_comb begin
        ras_fall = ras_q & ~ras_n;
        cas_fall = cas_q & ~cas_n;
        cbr_fire = ras_fall & pend_q & ~cas_n;
        act_fire = ras_fall & ~cbr_fire;
        acc      = cas_fall & ~ras_n & (cyc_q == CYC_OPEN);
        rd_en    = acc & we_n;
        wr_en    = acc & ~we_n;
        acc_row  = row_q;
        acc_col  = addr;
        ref_en   = ras_fall | acc;
        // data selector: open row, internal counter or external bus
        if (acc)           ref_row = row_q;
        else if (cbr_fire) ref_row = ref_cnt;
        else               ref_row = addr;
    end

    // Previous strobe samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
        end
    end

    // Pending counter refresh: CAS fell while RAS was high
    always_ff @(posedge clk) begin
        if (!rst_n)                 pend_q <= 1'b0;
        else if (cas_n)             pend_q <= 1'b0;
        else if (cas_fall && ras_n) pend_q <= 1'b1;
        else if (cbr_fire)          pend_q <= 1'b0;
    end

    // RAS cycle kind and row address latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= CYC_IDLE;
            row_q <= '0;
        end else if (ras_n) begin
            cyc_q <= CYC_IDLE;
        end else if (cbr_fire) begin
            cyc_q <= CYC_CBR;
        end else if (act_fire) begin
            cyc_q <= CYC_OPEN;
            row_q <= addr;
        end
    end

    a_r6_access_needs_open_row: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) |-> $past(!ras_n));
    a_r9_cbr_needs_early_cas: assert property (@(posedge clk) disable iff (!rst_n)
        cbr_fire |-> $past(!cas_n) && $past(ras_n));
    a_r9_cbr_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        cbr_fire |=> !(rd_en || wr_en));
endmodule

// File: rtl/dram_cell_array.sv
// Square bit array for the DRAM model, with optional per-row decay.
// Each row is its own register. When DECAY_EN is set, each row also has an
// age timer that restarts on any refresh hit; a row whose timer reaches
// RETAIN is cleared to zero. Reads are registered.
// Assumes: a write always comes with a refresh hit on the same row.
module dram_cell_array #(
    parameter int AW       = 5,
    parameter bit DECAY_EN = 1'b1,
    parameter int RETAIN   = 2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_en,
    input  logic [AW-1:0] ref_row,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] row,
    input  logic [AW-1:0] col,
    input  logic          din,
    output logic          rd_bit
);
    localparam int ROWS = 1 << AW;
    localparam int COLS = 1 << AW;
    localparam int AGEW = $clog2(RETAIN + 1);

    logic [ROWS-1:0][COLS-1:0] bits;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam logic [AW-1:0] RIDX = AW'(r);
        logic            hit;
        logic            wipe;
        logic [COLS-1:0] q;

        assign hit     = ref_en && (ref_row == RIDX);
        assign bits[r] = q;

        if (DECAY_EN) begin : g_age
            logic [AGEW-1:0] age_q;
            // Age since last refresh, saturating at RETAIN
            always_ff @(posedge clk) begin
                if (!rst_n)                          age_q <= '0;
                else if (hit)                        age_q <= '0;
                else if (age_q != AGEW'(RETAIN))     age_q <= age_q + 1'b1;
            end
            assign wipe = !hit && (age_q == AGEW'(RETAIN - 1));

            a_r7_expired_row_empty: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q == AGEW'(RETAIN)) |-> (q == '0));
        end else begin : g_keep
            assign wipe = 1'b0;
        end

        // Row storage: single-cell write, or clear on expiry
        always_ff @(posedge clk) begin
            if (!rst_n)                     q <= '0;
            else if (wr_en && row == RIDX)  q[col] <= din;
            else if (wipe)                  q <= '0;
        end
    end

    // Registered read of the addressed cell
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_bit <= 1'b0;
        else if (rd_en) rd_bit <= bits[row][col];
    end

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bits[$past(row)][$past(col)] == $past(din));
    a_r5_one_cell_only: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $countones(bits[$past(row)] ^ $past(bits[row])) <= 1);
endmodule

// File: rtl/dram_mux_model.sv
// Top of the multiplexed-address DRAM model.
// Wires the strobe controller, refresh counter and cell array together, and
// owns the output valid flag that follows CAS.
// Assumes: all inputs synchronous to clk; default size is 32 x 32 bits.
module dram_mux_model #(
    parameter int AW       = 5,
    parameter bit DECAY_EN = 1'b1,
    parameter int RETAIN   = 2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic          din,
    output logic          dout,
    output logic          dout_valid
);
    logic          ref_en, cbr_fire, rd_en, wr_en, rd_bit;
    logic [AW-1:0] ref_row, acc_row, acc_col, ref_cnt;
    logic          valid_q;

    dram_strobe_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ref_cnt(ref_cnt), .ref_en(ref_en), .ref_row(ref_row),
        .cbr_fire(cbr_fire), .rd_en(rd_en), .wr_en(wr_en),
        .acc_row(acc_row), .acc_col(acc_col)
    );

    dram_refresh_ctr #(.AW(AW)) u_rctr (
        .clk(clk), .rst_n(rst_n), .fire(cbr_fire), .cnt(ref_cnt)
    );

    dram_cell_array #(.AW(AW), .DECAY_EN(DECAY_EN), .RETAIN(RETAIN)) u_array (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .ref_row(ref_row),
        .wr_en(wr_en), .rd_en(rd_en), .row(acc_row), .col(acc_col),
        .din(din), .rd_bit(rd_bit)
    );

    // Output valid: set by a read, dropped whenever CAS is sampled high
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q <= 1'b0;
        else if (cas_n) valid_q <= 1'b0;
        else if (rd_en) valid_q <= 1'b1;
    end

    assign dout_valid = valid_q;
    assign dout       = valid_q & rd_bit;

    a_r4_off_when_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
        cas_n |=> !dout_valid);
    a_r4_valid_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_valid) |-> $past(rd_en));
endmodule

// File: tb/tb_dram_mux_model.sv
module tb_dram_mux_model;
    localparam int AW     = 5;
    localparam int ROWS   = 1 << AW;
    localparam int COLS   = 1 << AW;
    localparam int RETAIN = 2000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1;
    logic          cas_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          din = 1'b0;
    logic          dout, dout_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit sb [ROWS][COLS];
    int cur_row = 0;
    int cbr_count = 0;

    always #4 clk = ~clk;

    dram_mux_model #(.AW(AW), .DECAY_EN(1'b1), .RETAIN(RETAIN)) dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_valid(dout_valid)
    );

    function automatic bit exp_bit(int r, int c);
        return sb[r][c];
    endfunction

    function automatic int next_cbr_row(int n);
        return n % ROWS;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic open_row(int r);
        addr = AW'(r); ras_n = 1'b0; cur_row = r;
        tick(1);
    endtask

    task automatic close_row();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        tick(1);
    endtask

    task automatic page_write(int c, bit b);
        addr = AW'(c); din = b; we_n = 1'b0; cas_n = 1'b0;
        tick(1);
        chk("R4 write keeps valid low", dout_valid, 0);
        sb[cur_row][c] = b;
        cas_n = 1'b1; we_n = 1'b1;
        tick(1);
    endtask

    task automatic page_read(int c, string req);
        addr = AW'(c); we_n = 1'b1; cas_n = 1'b0;
        tick(1);
        chk({req, " valid"}, dout_valid, 1);
        chk({req, " data"}, dout, exp_bit(cur_row, c));
        cas_n = 1'b1;
        tick(1);
        chk("R4 cas high drops valid", dout_valid + dout, 0);
    endtask

    task automatic ras_only(int r);
        addr = AW'(r); ras_n = 1'b0;
        tick(1);
        ras_n = 1'b1;
        tick(1);
    endtask

    task automatic sweep();
        for (int r = 0; r < ROWS; r++) ras_only(r);
    endtask

    task automatic cbr_cycle();
        addr = AW'(ROWS - 1);
        cas_n = 1'b0;
        tick(1);
        ras_n = 1'b0;
        tick(1);
        chk("R9 no output in counter refresh", dout_valid, 0);
        ras_n = 1'b1;
        tick(1);
        cas_n = 1'b1;
        tick(1);
        cbr_count++;
    endtask

    task automatic mark_all_rows();
        for (int r = 0; r < ROWS; r++) begin
            open_row(r);
            page_write(5, 1'b1);
            close_row();
        end
    endtask

    initial begin
        bit refreshed [ROWS];
        void'($urandom(32'h5EED_0C11));
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) sb[r][c] = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 valid after reset", dout_valid, 0);
        chk("R1 dout after reset", dout, 0);

        // R1 cells empty, then R3 fast page write/read in one open row
        open_row(3);
        for (int c = 0; c < 8; c++) page_read(c, "R1 empty cell");
        for (int c = 0; c < 8; c++) page_write(c, bit'((8'hA5 >> c) & 1));
        for (int c = 0; c < 8; c++) page_read(c, "R3 page readback");
        close_row();

        // R5 single-cell write: flip col 2, neighbours must hold
        open_row(3);
        page_write(2, ~sb[3][2]);
        page_read(1, "R5 left neighbour");
        page_read(2, "R5 target");
        page_read(3, "R5 right neighbour");
        close_row();
        open_row(4);
        page_read(2, "R5 other row");
        close_row();

        // R2 constrained random accesses
        for (int op = 0; op < 80; op++) begin
            int n;
            open_row(int'($urandom_range(ROWS - 1)));
            n = int'($urandom_range(4, 1));
            for (int k = 0; k < n; k++) begin
                int c;
                c = int'($urandom_range(COLS - 1));
                if ($urandom_range(1) == 1) page_write(c, bit'($urandom_range(1)));
                else page_read(c, "R2 random read");
            end
            close_row();
        end

        // R6 stray CAS with RAS high: no write, no output, no counter step
        open_row(3);
        page_read(2, "R2 before stray strobe");
        close_row();
        addr = AW'(2); din = ~sb[3][2]; we_n = 1'b0; cas_n = 1'b0;
        tick(3);
        chk("R6 stray CAS no output", dout_valid, 0);
        cas_n = 1'b1; we_n = 1'b1;
        tick(1);
        open_row(3);
        page_read(2, "R6 cell unchanged");
        close_row();

        // R8 RAS-only refresh keeps data over more than RETAIN cycles
        sweep();
        tick(1200);
        sweep();
        tick(1200);
        for (int r = 0; r < ROWS; r++) begin
            open_row(r);
            page_read(r, "R8 retained");
            page_read((r + 7) % COLS, "R8 retained");
            close_row();
        end

        // R9/R7/R10 counter refresh from reset value, external addr ignored
        mark_all_rows();
        sweep();
        tick(800);
        for (int r = 0; r < ROWS; r++) refreshed[r] = 1'b0;
        for (int k = 0; k < ROWS / 2; k++) begin
            refreshed[next_cbr_row(cbr_count)] = 1'b1;
            cbr_cycle();
        end
        tick(700);
        open_row(20);
        page_read(5, "R10 read keeps row");
        close_row();
        refreshed[20] = 1'b1;
        tick(700);
        for (int r = 0; r < ROWS; r++)
            if (!refreshed[r])
                for (int c = 0; c < COLS; c++) sb[r][c] = 1'b0;
        for (int r = 0; r < ROWS; r++) begin
            open_row(r);
            page_read(5, refreshed[r] ? "R9 counter row kept" : "R7 stale row lost");
            page_read(r, refreshed[r] ? "R9 counter row kept" : "R7 stale row lost");
            close_row();
        end

        // R9 wrap: rows 16..31 then row 0; row 1 must decay
        mark_all_rows();
        sweep();
        tick(800);
        for (int r = 0; r < ROWS; r++) refreshed[r] = 1'b0;
        for (int k = 0; k < ROWS / 2 + 1; k++) begin
            refreshed[next_cbr_row(cbr_count)] = 1'b1;
            cbr_cycle();
        end
        tick(1400);
        for (int r = 0; r < ROWS; r++)
            if (!refreshed[r])
                for (int c = 0; c < COLS; c++) sb[r][c] = 1'b0;
        chk("R9 wrapped row refreshed", int'(refreshed[0]), 1);
        open_row(0);  page_read(5, "R9 wrap row 0 kept");  close_row();
        open_row(1);  page_read(5, "R9 row 1 lost");       close_row();
        open_row(15); page_read(5, "R7 row 15 lost");      close_row();
        open_row(16); page_read(5, "R9 row 16 kept");      close_row();
        open_row(31); page_read(5, "R9 row 31 kept");      close_row();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule